// File: doc/BRIEF.md
# Dual-Group Registered Bus Transceiver Core

This block is the logic core of a 16-bit, two-way bus transceiver. The data path is split into two independent 8-bit groups. Each group carries data from an A side to a B side and from B back to A. Every direction of every group has its own storage element. Depending on its latch enable, that element either passes data straight through or presents the value captured on the most recent rising edge of the one shared clock. Tri-state pads are kept outside the block: each port has a data output and a per-bit drive enable, and a pad ring turns these into real three-state drivers.

Drive is decided at two levels. Each group has an active-low enable for each direction. An active-low global enable, shared by both groups, overrides all of them. A keeper on the A side stands in for floating inputs: a per-bit flag marks a line as undriven, and while it is set the core uses the last value it saw on that line. An active-low asynchronous reset clears every storage element and keeper bit to zero.

The latch enables are sampled as logic levels by a fully synchronous design. Between clock edges a direction with its latch enable low shows a steady value. When the latch enable is high, the output follows the input combinationally.

Top module: `xcvr_core`

## Requirements
- R1: With `le_ab[g]` high, `b_out` bits of group g equal the effective A value (see R7) in the same cycle, with no clock edge needed.
- R2: With `le_ab[g]` low, `b_out` bits of group g equal the effective A value captured at the most recent rising edge of `clk`, and they stay steady between edges.
- R3: The B-to-A direction behaves as R1 and R2 do, using `le_ba[g]`, `b_in` and `a_out`, with the same clock.
- R4: While `oe_all_n` is 1, every bit of `a_oe` and `b_oe` is 0, whatever the per-group enables are.
- R5: While `oe_all_n` is 0, `b_oe` bits of group g are 1 exactly when `oe_ab_n[g]` is 0, and `a_oe` bits of group g are 1 exactly when `oe_ba_n[g]` is 0. This covers all four enable combinations.
- R6: Group g covers bits [8g+7:8g]. The enables and latch enables of one group affect no output bit of the other group.
- R7: While `a_float[i]` is 1, the effective A value of bit i is the last `a_in[i]` that was sampled at a rising edge while `a_float[i]` was 0. While `a_float[i]` is 0, the effective value is `a_in[i]`.
- R8: While `rst_n` is 0, all storage and keeper bits are 0, so a direction with its latch enable low outputs all zeros.
- R9: Switching an output enable on or off never changes a stored value. Data outputs carry the stored value whatever the drive state is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared capture clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low clear |
| oe_all_n | input | 1 | Global active-low output enable |
| oe_ab_n | input | 2 | Per-group active-low B-side drive enable |
| oe_ba_n | input | 2 | Per-group active-low A-side drive enable |
| le_ab | input | 2 | Per-group A-to-B latch enable (1 = pass-through) |
| le_ba | input | 2 | Per-group B-to-A latch enable (1 = pass-through) |
| a_in | input | 16 | Value seen on the A pads |
| a_float | input | 16 | Per-bit flag, A pad undriven |
| b_in | input | 16 | Value seen on the B pads |
| a_out | output | 16 | Data toward the A pads |
| a_oe | output | 16 | Per-bit A pad drive enable |
| b_out | output | 16 | Data toward the B pads |
| b_oe | output | 16 | Per-bit B pad drive enable |

## Verification
A corrupted storage bit appears on the data output one clock after the faulty capture, as soon as that direction's latch enable is low. In pass-through mode it stays hidden until the latch enable falls. A stuck keeper bit appears only while its float flag is set, and then at once in pass-through mode or after one edge in registered mode. The bench therefore floats lines in both modes. Drive decode faults are purely combinational and show in the same cycle. The bench steps through all four per-group enable combinations with the two groups set differently, so that crossed group wiring is exposed.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    typedef enum logic [1:0] {
        DRV_NONE = 2'b00,
        DRV_A    = 2'b01,
        DRV_B    = 2'b10,
        DRV_BOTH = 2'b11
    } drive_e;

    // Resolve the three active-low enables of one group into a drive mode.
    function automatic drive_e decode_drive(input logic all_n,
                                            input logic ab_n,
                                            input logic ba_n);
        drive_e m;
        if (all_n)
            m = DRV_NONE;
        else begin
            unique case ({ab_n, ba_n})
                2'b00:   m = DRV_BOTH;
                2'b01:   m = DRV_B;
                2'b10:   m = DRV_A;
                default: m = DRV_NONE;
            endcase
        end
        return m;
    endfunction

endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pass,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    typedef struct packed {
        logic [WIDTH-1:0] held;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.held = din;
        dout      = pass ? din : st_q.held;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end
endmodule

// File: rtl/xcvr_keeper.sv
module xcvr_keeper #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin,
    input  logic [WIDTH-1:0] undriven,
    output logic [WIDTH-1:0] level
);
    typedef struct packed {
        logic [WIDTH-1:0] last;
    } keep_t;

    keep_t kp_d, kp_q;

    always_comb begin
        kp_d = kp_q;
        for (int i = 0; i < WIDTH; i++) begin
            if (!undriven[i])
                kp_d.last[i] = pin[i];
            level[i] = undriven[i] ? kp_q.last[i] : pin[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            kp_q <= '0;
        else
            kp_q <= kp_d;
    end
endmodule

// File: rtl/xcvr_drive.sv
module xcvr_drive
    import xcvr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             all_n,
    input  logic             ab_n,
    input  logic             ba_n,
    output logic [WIDTH-1:0] a_en,
    output logic [WIDTH-1:0] b_en
);
    drive_e mode;

    always_comb begin
        mode = decode_drive(all_n, ab_n, ba_n);
        a_en = {WIDTH{(mode == DRV_A) || (mode == DRV_BOTH)}};
        b_en = {WIDTH{(mode == DRV_B) || (mode == DRV_BOTH)}};
    end
endmodule

// File: rtl/xcvr_core.sv
module xcvr_core #(
    parameter int HALVES = 2,
    parameter int LANE_W = 8,
    localparam int W     = HALVES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              oe_all_n,
    input  logic [HALVES-1:0] oe_ab_n,
    input  logic [HALVES-1:0] oe_ba_n,
    input  logic [HALVES-1:0] le_ab,
    input  logic [HALVES-1:0] le_ba,
    input  logic [W-1:0]      a_in,
    input  logic [W-1:0]      a_float,
    input  logic [W-1:0]      b_in,
    output logic [W-1:0]      a_out,
    output logic [W-1:0]      a_oe,
    output logic [W-1:0]      b_out,
    output logic [W-1:0]      b_oe
);
    logic [W-1:0] a_eff;

    xcvr_keeper #(.WIDTH(W)) u_keep (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (a_in),
        .undriven (a_float),
        .level    (a_eff)
    );

    for (genvar g = 0; g < HALVES; g++) begin : g_grp
        localparam int LO = g * LANE_W;

        xcvr_store #(.WIDTH(LANE_W)) u_ab (
            .clk   (clk),
            .rst_n (rst_n),
            .pass  (le_ab[g]),
            .din   (a_eff[LO +: LANE_W]),
            .dout  (b_out[LO +: LANE_W])
        );

        xcvr_store #(.WIDTH(LANE_W)) u_ba (
            .clk   (clk),
            .rst_n (rst_n),
            .pass  (le_ba[g]),
            .din   (b_in[LO +: LANE_W]),
            .dout  (a_out[LO +: LANE_W])
        );

        xcvr_drive #(.WIDTH(LANE_W)) u_drv (
            .all_n (oe_all_n),
            .ab_n  (oe_ab_n[g]),
            .ba_n  (oe_ba_n[g]),
            .a_en  (a_oe[LO +: LANE_W]),
            .b_en  (b_oe[LO +: LANE_W])
        );
    end
endmodule

// File: rtl/xcvr_core_chk.sv
module xcvr_core_chk #(
    parameter int HALVES = 2,
    parameter int LANE_W = 8,
    localparam int W     = HALVES * LANE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              oe_all_n,
    input logic [HALVES-1:0] oe_ab_n,
    input logic [HALVES-1:0] oe_ba_n,
    input logic [HALVES-1:0] le_ab,
    input logic [HALVES-1:0] le_ba,
    input logic [W-1:0]      a_in,
    input logic [W-1:0]      a_float,
    input logic [W-1:0]      b_in,
    input logic [W-1:0]      a_out,
    input logic [W-1:0]      a_oe,
    input logic [W-1:0]      b_out,
    input logic [W-1:0]      b_oe
);
    logic started;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) started <= 1'b0;
        else        started <= 1'b1;
    end

    a_r4_global_off: assert property (@(posedge clk) disable iff (!rst_n)
        oe_all_n |-> (a_oe == '0 && b_oe == '0));

    for (genvar g = 0; g < HALVES; g++) begin : g_chk
        localparam int LO = g * LANE_W;

        a_r1_pass_ab: assert property (@(posedge clk) disable iff (!rst_n)
            (le_ab[g] && a_float[LO +: LANE_W] == '0)
            |-> b_out[LO +: LANE_W] == a_in[LO +: LANE_W]);

        a_r2_reg_ab: assert property (@(posedge clk) disable iff (!rst_n)
            (started && !le_ab[g] && $past(a_float[LO +: LANE_W]) == '0)
            |-> b_out[LO +: LANE_W] == $past(a_in[LO +: LANE_W]));

        a_r3_pass_ba: assert property (@(posedge clk) disable iff (!rst_n)
            le_ba[g] |-> a_out[LO +: LANE_W] == b_in[LO +: LANE_W]);

        a_r3_reg_ba: assert property (@(posedge clk) disable iff (!rst_n)
            (started && !le_ba[g])
            |-> a_out[LO +: LANE_W] == $past(b_in[LO +: LANE_W]));

        // R5 and R6: each group's drive follows its own enables only
        a_r5_b_drive: assert property (@(posedge clk) disable iff (!rst_n)
            !oe_all_n |-> b_oe[LO +: LANE_W] == {LANE_W{!oe_ab_n[g]}});

        a_r5_a_drive: assert property (@(posedge clk) disable iff (!rst_n)
            !oe_all_n |-> a_oe[LO +: LANE_W] == {LANE_W{!oe_ba_n[g]}});

        for (genvar j = 0; j < LANE_W; j++) begin : g_bit
            a_r7_keep_steady: assert property (@(posedge clk) disable iff (!rst_n)
                (started && le_ab[g] && $past(le_ab[g])
                 && a_float[LO + j] && $past(a_float[LO + j]))
                |-> $stable(b_out[LO + j]));
        end
    end
endmodule

bind xcvr_core xcvr_core_chk #(.HALVES(HALVES), .LANE_W(LANE_W)) u_chk (.*);

// File: tb/tb_xcvr_core.sv
module tb_xcvr_core;
    localparam int HALVES = 2;
    localparam int LANE_W = 8;
    localparam int W      = HALVES * LANE_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              oe_all_n = 1'b0;
    logic [HALVES-1:0] oe_ab_n = '0, oe_ba_n = '0, le_ab = '0, le_ba = '0;
    logic [W-1:0]      a_in = '0, a_float = '0, b_in = '0;
    logic [W-1:0]      a_out, a_oe, b_out, b_oe;

    // staged stimulus, applied by the driver at a falling edge
    logic              s_rst_n = 1'b0, s_all_n = 1'b0;
    logic [HALVES-1:0] s_ab_n = '0, s_ba_n = '0, s_le_ab = '0, s_le_ba = '0;
    logic [W-1:0]      s_a = '0, s_fl = '0, s_b = '0;

    // reference state built from the requirements
    logic [W-1:0] m_ab, m_ba, m_keep;

    int tests = 0, fails = 0;
    logic [4*W-1:0] exp_q[$];
    string          tag_q[$];
    bit             done = 1'b0;

    always #10 clk = ~clk;

    xcvr_core #(.HALVES(HALVES), .LANE_W(LANE_W)) dut (
        .clk(clk), .rst_n(rst_n), .oe_all_n(oe_all_n),
        .oe_ab_n(oe_ab_n), .oe_ba_n(oe_ba_n), .le_ab(le_ab), .le_ba(le_ba),
        .a_in(a_in), .a_float(a_float), .b_in(b_in),
        .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
    );

    function automatic logic [W-1:0] eff_a();
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) r[i] = a_float[i] ? m_keep[i] : a_in[i];
        return r;
    endfunction

    // R8: model cleared by reset; R2/R3/R7 captures at rising edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ab <= '0; m_ba <= '0; m_keep <= '0;
        end else begin
            m_ab <= eff_a();
            m_ba <= b_in;
            for (int i = 0; i < W; i++) if (!a_float[i]) m_keep[i] <= a_in[i];
        end
    end

    function automatic logic [4*W-1:0] expect_now();
        logic [W-1:0] ea, eb, eaoe, eboe, ae;
        ae = eff_a();
        for (int g = 0; g < HALVES; g++) begin
            for (int k = 0; k < LANE_W; k++) begin
                int i = g * LANE_W + k;
                eb[i]   = le_ab[g] ? ae[i] : m_ab[i];
                ea[i]   = le_ba[g] ? b_in[i] : m_ba[i];
                eboe[i] = !oe_all_n && !oe_ab_n[g];
                eaoe[i] = !oe_all_n && !oe_ba_n[g];
            end
        end
        return {ea, eaoe, eb, eboe};
    endfunction

    task automatic step(input string tag);
        @(negedge clk);
        rst_n = s_rst_n; oe_all_n = s_all_n; oe_ab_n = s_ab_n; oe_ba_n = s_ba_n;
        le_ab = s_le_ab; le_ba = s_le_ba; a_in = s_a; a_float = s_fl; b_in = s_b;
        #1;
        exp_q.push_back(expect_now());
        tag_q.push_back(tag);
    endtask

    // monitor: pops expectations and compares with the ports
    initial begin
        forever begin
            @(negedge clk);
            #3;
            while (exp_q.size() > 0) begin
                logic [4*W-1:0] e, act;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                act = {a_out, a_oe, b_out, b_oe};
                tests++;
                if (act !== e) begin
                    fails++;
                    $display("FAIL %s: actual a_out=%h a_oe=%h b_out=%h b_oe=%h expected a_out=%h a_oe=%h b_out=%h b_oe=%h",
                             t, act[4*W-1 -: W], act[3*W-1 -: W], act[2*W-1 -: W], act[W-1:0],
                             e[4*W-1 -: W], e[3*W-1 -: W], e[2*W-1 -: W], e[W-1:0]);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R8: reset state with registered mode on both directions
        s_rst_n = 0; s_a = 16'hA5C3; s_b = 16'h3C5A;
        step("R8 reset clears storage");
        step("R8 reset clears storage");
        s_rst_n = 1;
        step("R8 first cycle after reset");

        // R1: pass-through A to B, several patterns
        s_le_ab = 2'b11;
        s_a = 16'h1234; step("R1 pass-through");
        s_a = 16'hFFFF; step("R1 pass-through");
        s_a = 16'h0000; step("R1 pass-through");

        // R2: registered A to B, value from the previous edge
        s_le_ab = 2'b00;
        s_a = 16'hBEEF; step("R2 registered");
        s_a = 16'h5555; step("R2 registered");
        s_a = 16'hAAAA; step("R2 registered");

        // R3: B to A in both modes
        s_le_ba = 2'b11; s_b = 16'hC0DE; step("R3 pass-through");
        s_b = 16'h0F0F; step("R3 pass-through");
        s_le_ba = 2'b00; s_b = 16'h7E81; step("R3 registered");
        s_b = 16'h1111; step("R3 registered");

        // R6: groups in different modes
        s_le_ab = 2'b01; s_le_ba = 2'b10; s_a = 16'h9876; s_b = 16'h4321;
        step("R6 mixed modes");
        s_a = 16'h6789; s_b = 16'hDCBA; step("R6 mixed modes");

        // R5 / R6: all four enable combinations, groups differ
        for (int c = 0; c < 4; c++) begin
            s_ab_n = {c[0], c[1]};
            s_ba_n = {c[1], ~c[0]};
            step("R5 R6 enable decode");
        end

        // R4: global enable overrides everything
        s_all_n = 1; s_ab_n = 2'b00; s_ba_n = 2'b00; step("R4 global off");
        s_ab_n = 2'b10; s_ba_n = 2'b01; step("R4 global off");
        s_all_n = 0; s_ab_n = 2'b00; s_ba_n = 2'b00;

        // R9: toggling drive leaves stored data unchanged
        s_le_ab = 2'b00; s_le_ba = 2'b00; s_a = 16'h2468; s_b = 16'h1357;
        step("R9 load");
        s_ab_n = 2'b11; s_ba_n = 2'b11; step("R9 drive off");
        s_all_n = 1; step("R9 global off");
        s_all_n = 0; s_ab_n = 2'b00; s_ba_n = 2'b00; step("R9 drive back on");

        // R7: keeper in pass-through and registered modes
        s_le_ab = 2'b11; s_a = 16'h5A5A; s_fl = '0; step("R7 load keeper");
        s_fl = 16'hFFFF; s_a = 16'hFFFF; step("R7 float pass-through");
        s_a = 16'h0000; step("R7 float pass-through");
        s_le_ab = 2'b00; step("R7 float registered");
        step("R7 float registered");
        s_fl = 16'h00FF; s_a = 16'h1234; s_le_ab = 2'b11; step("R7 partial float");
        s_fl = '0; step("R7 float released");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule